// File: doc/BRIEF.md
# Strap-ID Device Select and Register Window Decoder

This block sits behind a firmware-hub style bus front end that has already turned the serial nibble stream into a decoded cycle. Each cycle arrives as a one-clock start strobe together with its device ID, a 32-bit address, a read/write flag and write data. The block compares the cycle ID with four strap pins. When they differ, the part drops out of the cycle and raises a standby indication until the next cycle begins. When they agree, the block serves accesses that fall inside its 64 KB register window. One location there passes the five general-purpose input pins straight through. Every other location in the window reads as zero.

The window for the boot device (strap 0000) starts at FFBC0000h. A device strapped with ID n has its window moved down by n × 4 MB, so several parts on one bus with counting-up straps never overlap. While an internal program or erase runs, register accesses are dropped silently: no response strobe appears, and the bus master sees a timeout.

Top module: `strap_reg_decoder`

## Requirements
- R1: During and right after reset, `standby` is 0, `rspValid` is 0 and `rdData` is 00h. `rdData` stays 00h in every cycle where `rspValid` is 0.
- R2: For a cycle whose `cycId` differs from `strapId`, `standby` is 1 in the clock after the start strobe and no `rspValid` pulse is produced.
- R3: `standby` keeps its value in every clock that follows a clock without a start strobe. A start strobe with a matching ID clears it in the next clock.
- R4: A matched cycle is a register access only when address bits 31:22 equal 3FEh minus `strapId` (10-bit arithmetic) and bits 21:16 equal 3Ch. For the boot device this is FFBC0000h to FFBCFFFFh.
- R5: A register read at window offset 0100h gives one `rspValid` pulse in the clock after the start strobe. Its `rdData` bits 4:0 are the GPI pins as sampled at the start-strobe edge, and bits 7:5 are 0.
- R6: A register read at any other window offset gives a `rspValid` pulse with `rdData` = 00h.
- R7: A register write gives a `rspValid` pulse with `rdData` = 00h. A write to offset 0100h has no effect: a later read still returns the live pins.
- R8: While `wrBusy` is 1 at the start strobe, a matched register access gives no `rspValid` pulse.
- R9: A matched cycle outside the register window gives no `rspValid` pulse and clears `standby`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycStart | input | 1 | One-clock strobe: a decoded cycle is present |
| cycId | input | 4 | Device ID field of the cycle |
| cycAddr | input | 32 | Cycle address |
| cycWrite | input | 1 | 1 = write, 0 = read |
| cycWdata | input | 8 | Write data |
| strapId | input | 4 | Strapped device ID |
| gpiPins | input | 5 | General-purpose input pins |
| wrBusy | input | 1 | Internal program/erase in progress |
| rdData | output | 8 | Read data, valid with rspValid |
| rspValid | output | 1 | One-clock response strobe |
| standby | output | 1 | Device deselected for the current cycle |

## Verification
Seeded random cycles mix matching and mismatching IDs, strap values across the whole range, addresses that hit the window, land at its edges or miss it, reads and writes, and a busy flag set about a quarter of the time. Each pattern tells apart a different mistake:
- Mismatches against matches expose the select compare.
- Non-zero straps expose a wrong window offset.
- Reads of offset 0100h against its neighbours expose the offset decode and the pin pass-through.
- Busy cycles expose a response that should have been suppressed.

Directed cases cover standby holding across idle clocks, a write to the input register followed by a read-back, and the top window of the highest strap.

// File: rtl/strap_reg_pkg.sv
package strap_reg_pkg;
  // strobes handed from control to datapath for one decoded cycle
  typedef struct packed {
    logic respond;     // emit a response pulse next clock
    logic gpiRead;     // response carries the pin pass-through
    logic setStandby;  // ID mismatch: deselect
    logic clrStandby;  // ID match: reselect
  } ctrlStrobes_t;
endpackage

// File: rtl/strap_reg_ctrl.sv
module strap_reg_ctrl
  import strap_reg_pkg::*;
#(
  parameter int ID_W      = 4,
  parameter int ADDR_W    = 32,
  parameter int PAGE_LSB  = 22,
  parameter int SUB_LSB   = 16,
  parameter logic [ADDR_W-PAGE_LSB-1:0] WIN_PAGE = 10'h3FE,
  parameter logic [PAGE_LSB-SUB_LSB-1:0] WIN_SUB = 6'h3C,
  parameter logic [SUB_LSB-1:0] GPI_OFS = 16'h0100
) (
  input  logic              cycStart,
  input  logic [ID_W-1:0]   cycId,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic              cycWrite,
  input  logic [ID_W-1:0]   strapId,
  input  logic              wrBusy,
  output ctrlStrobes_t      strobes
);
  localparam int PAGE_W = ADDR_W - PAGE_LSB;
  localparam int SUB_W  = PAGE_LSB - SUB_LSB;

  logic              idMatch;
  logic [PAGE_W-1:0] ownPage;
  logic              pageHit;
  logic              subHit;
  logic              inWindow;
  logic              atGpi;
  logic              regAccess;

  // each strap step moves the window down one page (4 MB by default)
  assign ownPage  = WIN_PAGE - PAGE_W'(strapId);
  assign idMatch  = (cycId == strapId);
  assign pageHit  = (cycAddr[ADDR_W-1:PAGE_LSB] == ownPage);
  assign subHit   = (cycAddr[PAGE_LSB-1:SUB_LSB] == SUB_W'(WIN_SUB));
  assign inWindow = pageHit && subHit;
  assign atGpi    = (cycAddr[SUB_LSB-1:0] == GPI_OFS);
  assign regAccess = cycStart && idMatch && inWindow && !wrBusy;

  always_comb begin
    strobes            = '0;
    strobes.setStandby = cycStart && !idMatch;
    strobes.clrStandby = cycStart && idMatch;
    strobes.respond    = regAccess;
    strobes.gpiRead    = regAccess && atGpi && !cycWrite;
  end
endmodule

// File: rtl/strap_reg_datapath.sv
module strap_reg_datapath
  import strap_reg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int GPI_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [GPI_W-1:0]  gpiPins,
  output logic [DATA_W-1:0] rdData,
  output logic              rspValid,
  output logic              standby
);
  localparam int PAD_W = DATA_W - GPI_W;

  logic [DATA_W-1:0] gpiWord;
  logic [DATA_W-1:0] dataNext;

  // live pins in the low bits, reserved upper bits forced low
  generate
    if (PAD_W > 0) begin : g_pad
      assign gpiWord = {{PAD_W{1'b0}}, gpiPins};
    end else begin : g_nopad
      assign gpiWord = gpiPins[DATA_W-1:0];
    end
  endgenerate

  assign dataNext = strobes.gpiRead ? gpiWord : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData   <= '0;
      rspValid <= 1'b0;
      standby  <= 1'b0;
    end else begin
      rspValid <= strobes.respond;
      rdData   <= dataNext;
      if (strobes.setStandby)      standby <= 1'b1;
      else if (strobes.clrStandby) standby <= 1'b0;
    end
  end
endmodule

// File: rtl/strap_reg_decoder.sv
module strap_reg_decoder
  import strap_reg_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int GPI_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycStart,
  input  logic [ID_W-1:0]   cycId,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic              cycWrite,
  input  logic [DATA_W-1:0] cycWdata,
  input  logic [ID_W-1:0]   strapId,
  input  logic [GPI_W-1:0]  gpiPins,
  input  logic              wrBusy,
  output logic [DATA_W-1:0] rdData,
  output logic              rspValid,
  output logic              standby
);
  ctrlStrobes_t strobes;
  logic unusedWdata;

  // the only writable location ignores data, so the payload is dropped
  assign unusedWdata = ^cycWdata;

  strap_reg_ctrl #(
    .ID_W(ID_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .cycStart(cycStart), .cycId(cycId), .cycAddr(cycAddr),
    .cycWrite(cycWrite), .strapId(strapId), .wrBusy(wrBusy),
    .strobes(strobes)
  );

  strap_reg_datapath #(
    .DATA_W(DATA_W), .GPI_W(GPI_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .gpiPins(gpiPins),
    .rdData(rdData), .rspValid(rspValid), .standby(standby)
  );
endmodule

// File: rtl/strap_reg_decoder_chk.sv
module strap_reg_decoder_chk #(
  parameter int ID_W   = 4,
  parameter int DATA_W = 8,
  parameter int GPI_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycStart,
  input logic [ID_W-1:0]   cycId,
  input logic [ID_W-1:0]   strapId,
  input logic              wrBusy,
  input logic [DATA_W-1:0] rdData,
  input logic              rspValid,
  input logic              standby
);
  AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rstN) !rspValid |-> rdData == '0); // R1
  AST_MISMATCH_SILENT: assert property (@(posedge clk) disable iff (!rstN) rspValid |-> $past(cycId == strapId)); // R2
  AST_STANDBY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(standby && rspValid)); // R2
  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rstN) !$past(cycStart) |-> $stable(standby)); // R3
  AST_RSP_AFTER_START: assert property (@(posedge clk) disable iff (!rstN) rspValid |-> $past(cycStart)); // R5
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN) rspValid |-> rdData[DATA_W-1:GPI_W] == '0); // R5
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rstN) rspValid |-> !$past(wrBusy)); // R8
endmodule

bind strap_reg_decoder strap_reg_decoder_chk #(
  .ID_W(ID_W), .DATA_W(DATA_W), .GPI_W(GPI_W)
) u_chk (
  .clk(clk), .rstN(rstN), .cycStart(cycStart), .cycId(cycId),
  .strapId(strapId), .wrBusy(wrBusy), .rdData(rdData),
  .rspValid(rspValid), .standby(standby)
);

// File: tb/strap_reg_decoder_tb.sv
module strap_reg_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycStart = 1'b0;
  logic [3:0]  cycId = '0;
  logic [31:0] cycAddr = '0;
  logic        cycWrite = 1'b0;
  logic [7:0]  cycWdata = '0;
  logic [3:0]  strapId = '0;
  logic [4:0]  gpiPins = '0;
  logic        wrBusy = 1'b0;
  logic [7:0]  rdData;
  logic        rspValid;
  logic        standby;

  int checks = 0;
  int fails = 0;
  logic modelStandby = 1'b0;

  always #2.5 clk = ~clk;

  strap_reg_decoder u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // window page for a strap value per R4
  function automatic logic [9:0] pageOf(input logic [3:0] s);
    return 10'h3FE - {6'd0, s};
  endfunction

  function automatic logic [31:0] winAddr(input logic [3:0] s, input logic [15:0] ofs);
    return {pageOf(s), 6'h3C, ofs};
  endfunction

  // one cycle: drive at negedge, sample at the negedge after the capturing edge
  task automatic runCycle(input logic [3:0] id, input logic [31:0] addr,
                          input logic wr, input logic busy, input string tag);
    logic match, inWin, expValid;
    logic [7:0] expData;
    @(negedge clk);
    cycStart = 1'b1; cycId = id; cycAddr = addr; cycWrite = wr;
    cycWdata = 8'($urandom); wrBusy = busy;
    match = (id == strapId);
    inWin = (addr[31:22] == pageOf(strapId)) && (addr[21:16] == 6'h3C);
    expValid = match && inWin && !busy;
    expData = (expValid && !wr && addr[15:0] == 16'h0100) ? {3'b000, gpiPins} : 8'h00;
    modelStandby = !match;
    @(negedge clk);
    cycStart = 1'b0; wrBusy = 1'b0;
    check({tag, " rspValid"}, 32'(rspValid), 32'(expValid));
    check({tag, " rdData"}, 32'(rdData), 32'(expData));
    check({tag, " standby"}, 32'(standby), 32'(modelStandby));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    check("R1 reset standby", 32'(standby), 0);
    check("R1 reset rspValid", 32'(rspValid), 0);
    check("R1 reset rdData", 32'(rdData), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset rdData", 32'(rdData), 0);

    // directed: boot device reads the GPI register (R4, R5)
    strapId = 4'd0; gpiPins = 5'h15;
    runCycle(4'd0, 32'hFFBC0100, 1'b0, 1'b0, "R5 boot gpi read");
    runCycle(4'd0, 32'hFFBC0101, 1'b0, 1'b0, "R6 unused offset");
    runCycle(4'd0, 32'hFFBC0000, 1'b0, 1'b0, "R6 window base");
    // write then read-back (R7)
    runCycle(4'd0, 32'hFFBC0100, 1'b1, 1'b0, "R7 gpi write");
    gpiPins = 5'h0A;
    runCycle(4'd0, 32'hFFBC0100, 1'b0, 1'b0, "R7 read after write");
    // busy suppression (R8)
    runCycle(4'd0, 32'hFFBC0100, 1'b0, 1'b1, "R8 busy read");
    runCycle(4'd0, 32'hFFBC0100, 1'b1, 1'b1, "R8 busy write");
    // mismatch then idle hold, then reselect (R2, R3)
    runCycle(4'd2, 32'hFFBC0100, 1'b0, 1'b0, "R2 mismatch");
    repeat (4) @(negedge clk);
    check("R3 standby held idle", 32'(standby), 1);
    check("R1 idle rdData", 32'(rdData), 0);
    runCycle(4'd0, 32'h00001000, 1'b0, 1'b0, "R9 out of window clears");
    // offset strap (R4): top strap window and boot address misses
    strapId = 4'd15;
    runCycle(4'd15, winAddr(4'd15, 16'h0100), 1'b0, 1'b0, "R4 strap15 gpi");
    runCycle(4'd15, 32'hFFBC0100, 1'b0, 1'b0, "R4 strap15 boot addr");
    strapId = 4'd3;
    runCycle(4'd3, winAddr(4'd3, 16'hFFFF), 1'b0, 1'b0, "R6 strap3 window top");
    runCycle(4'd3, {pageOf(4'd3), 6'h3D, 16'h0100}, 1'b0, 1'b0, "R9 strap3 wrong sub");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] id;
      logic [31:0] addr;
      if ($urandom_range(0, 9) == 0) strapId = 4'($urandom);
      gpiPins = 5'($urandom);
      id = ($urandom_range(0, 3) == 0) ? 4'($urandom) : strapId;
      case ($urandom_range(0, 3))
        0: addr = winAddr(id, 16'h0100);
        1: addr = winAddr(id, 16'($urandom));
        2: addr = winAddr(4'($urandom), 16'h0100);
        default: addr = $urandom;
      endcase
      runCycle(id, addr, 1'($urandom), ($urandom_range(0, 3) == 0), "R2-R9 random");
      if ($urandom_range(0, 4) == 0) begin
        repeat ($urandom_range(1, 3)) @(negedge clk);
        check("R3 random idle standby", 32'(standby), 32'(modelStandby));
        check("R1 random idle rspValid", 32'(rspValid), 0);
      end
    end

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule